// File: doc/BRIEF.md
# SDRAM Bank Timing Monitor

A passive, synthesizable monitor for the command bus of a four-bank single-data-rate SDRAM. Each cycle it samples the chip-select, row-strobe, column-strobe and write-enable lines, the two bank-select bits and eleven address bits. It decodes them into a command and keeps, for every bank, the idle/active state, the open row and a saturating count of cycles since that bank was last activated. A second count tracks the cycles since the last activate to any bank.

The monitor only observes the bus and never drives it. Every command is checked against five spacing rules, and each rule's limit is a module parameter counted in clock cycles:

- activate-to-access,
- activate-to-activate on the same bank,
- activate-to-activate across banks,
- minimum active time before precharge,
- maximum active time.

When a command breaks a rule, the monitor reports a per-cycle flag with a code and also sets a sticky bit for that code. A bank held open too long raises a level flag. Refresh, mode programming, data-bus checks and power-down are not handled.

Top module: `sdram_bank_timing_mon`

## Requirements
- R1: Decoding, shown on `cmd_o` one cycle after the command is sampled:
  - `cs_ni`=1, or all three strobes high, gives NOP=0.
  - Strobes (ras,cas,we)=(0,1,1) give ACT=1.
  - Strobes (0,1,0) give PRE=2 when address bit 10 is 0, and PREA=3 when it is 1.
  - Strobes (1,0,1) with bit 10 at 0 give RD=4.
  - Strobes (1,0,0) with bit 10 at 0 give WR=5.
  - Every other encoding gives OTHER=7 and changes no state.
- R2: An ACT marks the bank selected by `ba_i` active and records `addr_i` as its open row. Both show on `bank_active_o[ba]` and `open_row_o[ba*11 +: 11]` one cycle later.
- R3: A PRE with bit 10 at 0 makes only the selected bank idle. A PRE to an already idle bank raises no violation.
- R4: A PREA makes all banks idle whatever `ba_i` holds. It is legal when some or all banks are already idle.
- R5: A RD or WR to an active bank fewer than T_RCD cycles after that bank's ACT gives code 1.
- R6: A RD or WR to an idle bank gives code 2 and changes no bank state. Code 2 takes priority over code 1.
- R7: An ACT to a bank that is already active gives code 3. The new row is still recorded and the bank's timer restarts.
- R8: An ACT to an idle bank fewer than T_RC cycles after that bank's previous ACT gives code 4.
- R9: An ACT to a bank other than the most recently activated one, fewer than T_RRD cycles after that ACT, gives code 5. When several rules fail on one ACT, the code chosen is 3, then 4, then 5, in that order.
- R10: A PRE or PREA that closes an active bank fewer than T_RAS_MIN cycles after its ACT gives code 6.
- R11: `overdue_o[b]` is high while bank b is active and more than T_RAS_MAX cycles have passed since its ACT.
- R12: `viol_o` and `viol_code_o` show the result for the command sampled one cycle earlier. `viol_sticky_o[code]` is set in the same cycle and holds until reset. `viol_sticky_o[7]` is set one cycle after any `overdue_o` bit is high. Bit 0 stays 0.
- R13: Reset leaves every bank idle, all outputs zero and all timers expired, so the first commands after reset break no spacing rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 11 | Address; bit 10 selects all-bank precharge |
| cmd_o | output | 3 | Decoded command of the previous cycle |
| bank_active_o | output | 4 | Active flag per bank |
| open_row_o | output | 44 | Open row per bank, 11 bits each |
| overdue_o | output | 4 | Bank held active past T_RAS_MAX |
| viol_o | output | 1 | Previous command broke a rule |
| viol_code_o | output | 3 | Code of that violation |
| viol_sticky_o | output | 8 | Sticky flag per code |

## Verification
Command decode, bank state, open rows, the violation flag and code, and the sticky bits for codes 1–6 all appear after the one clock edge that samples the command. `overdue_o` is combinational from the bank timer and turns on T_RAS_MAX+1 edges after the ACT. The overdue sticky bit follows one edge after that.

The bench drives each command half a cycle before the sampling edge and compares all outputs at the following falling edge. Its expected values come from a reference model that is advanced by one cycle per step. That model keeps the overdue state from before the edge so it can predict the delayed sticky bit.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_PRE   = 3'd2,
    CMD_PREA  = 3'd3,
    CMD_RD    = 3'd4,
    CMD_WR    = 3'd5,
    CMD_OTHER = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    V_NONE    = 3'd0,
    V_RCD     = 3'd1,
    V_IDLE    = 3'd2,
    V_OPEN    = 3'd3,
    V_RC      = 3'd4,
    V_RRD     = 3'd5,
    V_RAS_MIN = 3'd6,
    V_OVERDUE = 3'd7
  } viol_e;

  localparam int NUM_CODES = 8;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 11,
  parameter int AP_BIT = 10
) (
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [BANK_W-1:0] ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cmd_e              cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] row_o
);

  logic ap;
  assign ap     = addr_i[AP_BIT];
  assign bank_o = ba_i;
  assign row_o  = addr_i;

  always_comb begin
    cmd_o = CMD_OTHER;
    if (cs_ni) begin
      cmd_o = CMD_NOP;
    end else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b111:  cmd_o = CMD_NOP;
        3'b011:  cmd_o = CMD_ACT;
        3'b010:  cmd_o = ap ? CMD_PREA : CMD_PRE;
        3'b101:  cmd_o = ap ? CMD_OTHER : CMD_RD;
        3'b100:  cmd_o = ap ? CMD_OTHER : CMD_WR;
        default: cmd_o = CMD_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer #(
  parameter int ROW_W     = 11,
  parameter int CNT_W     = 6,
  parameter int CNT_MAX   = 40,
  parameter int T_RCD     = 3,
  parameter int T_RC      = 9,
  parameter int T_RAS_MIN = 6,
  parameter int T_RAS_MAX = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             active_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rcd_ok_o,
  output logic             rc_ok_o,
  output logic             ras_ok_o,
  output logic             overdue_o
);

  localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic [ROW_W-1:0] row_q;

  // cnt_q equals the edge distance from the last activate, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= SAT;
    end else if (act_i) begin
      cnt_q <= CNT_W'(1);
    end else if (cnt_q != SAT) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      row_q    <= '0;
    end else if (act_i) begin
      active_q <= 1'b1;
      row_q    <= row_i;
    end else if (close_i) begin
      active_q <= 1'b0;
    end
  end

  assign active_o  = active_q;
  assign row_o     = row_q;
  assign rcd_ok_o  = cnt_q >= CNT_W'(T_RCD);
  assign rc_ok_o   = cnt_q >= CNT_W'(T_RC);
  assign ras_ok_o  = cnt_q >= CNT_W'(T_RAS_MIN);
  assign overdue_o = active_q && (cnt_q > CNT_W'(T_RAS_MAX));

  a_r2_act_opens_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> (active_o && row_o == $past(row_i)));

  a_r3_close_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_i && !act_i) |=> !active_o);

  a_r13_cnt_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0);

  a_r11_overdue_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overdue_o && !act_i && !close_i) |=> overdue_o);

endmodule

// File: rtl/sdram_act_spacing.sv
module sdram_act_spacing #(
  parameter int BANK_W  = 2,
  parameter int CNT_W   = 6,
  parameter int CNT_MAX = 40,
  parameter int T_RRD   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              rrd_viol_o
);

  localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_MAX);

  logic [CNT_W-1:0]  cnt_q;
  logic [BANK_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= SAT;
      last_q <= '0;
    end else if (act_i) begin
      cnt_q  <= CNT_W'(1);
      last_q <= bank_i;
    end else if (cnt_q != SAT) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign rrd_viol_o = act_i && (bank_i != last_q) && (cnt_q < CNT_W'(T_RRD));

  a_r9_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && act_i && $past(act_i) && bank_i != $past(bank_i) && T_RRD > 1)
      |-> rrd_viol_o);

  a_r9_same_bank_exempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && act_i && $past(act_i) && bank_i == $past(bank_i)) |-> !rrd_viol_o);

endmodule

// File: rtl/sdram_bank_timing_mon.sv
module sdram_bank_timing_mon
  import sdram_mon_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RC      = 9,
  parameter int T_RRD     = 2,
  parameter int T_RAS_MIN = 6,
  parameter int T_RAS_MAX = 30
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_ni,
  input  logic        ras_ni,
  input  logic        cas_ni,
  input  logic        we_ni,
  input  logic [1:0]  ba_i,
  input  logic [10:0] addr_i,
  output logic [2:0]  cmd_o,
  output logic [3:0]  bank_active_o,
  output logic [43:0] open_row_o,
  output logic [3:0]  overdue_o,
  output logic        viol_o,
  output logic [2:0]  viol_code_o,
  output logic [7:0]  viol_sticky_o
);

  localparam int BANK_W    = 2;
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int ROW_W     = 11;
  localparam int AP_BIT    = 10;
  localparam int M1 = (T_RAS_MAX + 1 > T_RC) ? T_RAS_MAX + 1 : T_RC;
  localparam int M2 = (M1 > T_RCD) ? M1 : T_RCD;
  localparam int M3 = (M2 > T_RAS_MIN) ? M2 : T_RAS_MIN;
  localparam int CNT_MAX = (M3 > T_RRD) ? M3 : T_RRD;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  cmd_e              dec_cmd;
  logic [BANK_W-1:0] dec_bank;
  logic [ROW_W-1:0]  dec_row;

  sdram_cmd_decode #(
    .BANK_W(BANK_W), .ADDR_W(ROW_W), .AP_BIT(AP_BIT)
  ) u_decode (
    .cs_ni (cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni),
    .ba_i  (ba_i),  .addr_i(addr_i),
    .cmd_o (dec_cmd), .bank_o(dec_bank), .row_o(dec_row)
  );

  logic [NUM_BANKS-1:0] act_hit, close_hit;
  logic [NUM_BANKS-1:0] active_w, rcd_ok_w, rc_ok_w, ras_ok_w, overdue_w;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign act_hit[b]   = (dec_cmd == CMD_ACT) && (dec_bank == BANK_W'(b));
    assign close_hit[b] = ((dec_cmd == CMD_PRE) && (dec_bank == BANK_W'(b)))
                          || (dec_cmd == CMD_PREA);

    sdram_bank_timer #(
      .ROW_W(ROW_W), .CNT_W(CNT_W), .CNT_MAX(CNT_MAX),
      .T_RCD(T_RCD), .T_RC(T_RC), .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX)
    ) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (act_hit[b]),
      .close_i  (close_hit[b]),
      .row_i    (dec_row),
      .active_o (active_w[b]),
      .row_o    (open_row_o[b*ROW_W +: ROW_W]),
      .rcd_ok_o (rcd_ok_w[b]),
      .rc_ok_o  (rc_ok_w[b]),
      .ras_ok_o (ras_ok_w[b]),
      .overdue_o(overdue_w[b])
    );
  end

  logic rrd_viol;

  sdram_act_spacing #(
    .BANK_W(BANK_W), .CNT_W(CNT_W), .CNT_MAX(CNT_MAX), .T_RRD(T_RRD)
  ) u_spacing (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (dec_cmd == CMD_ACT),
    .bank_i    (dec_bank),
    .rrd_viol_o(rrd_viol)
  );

  viol_e code_d;

  always_comb begin
    code_d = V_NONE;
    unique case (dec_cmd)
      CMD_ACT: begin
        if (active_w[dec_bank])     code_d = V_OPEN;
        else if (!rc_ok_w[dec_bank]) code_d = V_RC;
        else if (rrd_viol)           code_d = V_RRD;
      end
      CMD_RD, CMD_WR: begin
        if (!active_w[dec_bank])      code_d = V_IDLE;
        else if (!rcd_ok_w[dec_bank]) code_d = V_RCD;
      end
      CMD_PRE: begin
        if (active_w[dec_bank] && !ras_ok_w[dec_bank]) code_d = V_RAS_MIN;
      end
      CMD_PREA: begin
        if (|(active_w & ~ras_ok_w)) code_d = V_RAS_MIN;
      end
      default: code_d = V_NONE;
    endcase
  end

  cmd_e                 cmd_q;
  viol_e                code_q;
  logic                 viol_q;
  logic [NUM_CODES-1:0] sticky_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= CMD_NOP;
      code_q   <= V_NONE;
      viol_q   <= 1'b0;
      sticky_q <= '0;
    end else begin
      cmd_q  <= dec_cmd;
      code_q <= code_d;
      viol_q <= code_d != V_NONE;
      if (code_d != V_NONE) sticky_q[code_d] <= 1'b1;
      if (|overdue_w) sticky_q[V_OVERDUE] <= 1'b1;
    end
  end

  assign cmd_o         = cmd_q;
  assign viol_o        = viol_q;
  assign viol_code_o   = code_q;
  assign viol_sticky_o = sticky_q;
  assign bank_active_o = active_w;
  assign overdue_o     = overdue_w;

  a_r4_prea_closes_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PREA) |-> (bank_active_o == '0));

  a_r12_sticky_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_sticky_o & $past(viol_sticky_o)) == $past(viol_sticky_o));

  a_r12_sticky_tracks_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> viol_sticky_o[viol_code_o]);

  a_r10_ras_on_precharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_code_o == V_RAS_MIN) |-> (cmd_o == CMD_PRE || cmd_o == CMD_PREA));

  a_r5_access_codes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_code_o == V_RCD || viol_code_o == V_IDLE) |-> (cmd_o == CMD_RD || cmd_o == CMD_WR));

  a_r7_act_codes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_code_o == V_OPEN || viol_code_o == V_RC || viol_code_o == V_RRD)
      |-> (cmd_o == CMD_ACT && bank_active_o != '0));

  a_r12_sticky_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !viol_sticky_o[0]);

endmodule

// File: tb/sdram_bank_timing_mon_bench.sv
module sdram_bank_timing_mon_bench;

  localparam int T_RCD = 3, T_RC = 9, T_RRD = 2, T_RAS_MIN = 6, T_RAS_MAX = 30;
  localparam int SATM = 1000000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic [1:0]  ba_i = '0;
  logic [10:0] addr_i = '0;
  logic [2:0]  cmd_o;
  logic [3:0]  bank_active_o;
  logic [43:0] open_row_o;
  logic [3:0]  overdue_o;
  logic        viol_o;
  logic [2:0]  viol_code_o;
  logic [7:0]  viol_sticky_o;

  always #10 clk_i = ~clk_i;

  sdram_bank_timing_mon #(
    .T_RCD(T_RCD), .T_RC(T_RC), .T_RRD(T_RRD), .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX)
  ) u_sdram_bank_timing_mon (
    .clk_i, .rst_ni, .cs_ni, .ras_ni, .cas_ni, .we_ni, .ba_i, .addr_i,
    .cmd_o, .bank_active_o, .open_row_o, .overdue_o, .viol_o, .viol_code_o, .viol_sticky_o
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model
  bit          m_act[4];
  logic [10:0] m_row[4];
  int          m_cnt[4];
  int          m_rrd;
  int          m_last;
  logic [7:0]  m_sticky;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int dec(input logic cs, ras, cas, we, a10);
    if (cs) return 0;
    case ({ras, cas, we})
      3'b111: return 0;
      3'b011: return 1;
      3'b010: return a10 ? 3 : 2;
      3'b101: return a10 ? 7 : 4;
      3'b100: return a10 ? 7 : 5;
      default: return 7;
    endcase
  endfunction

  function automatic int rule(input int c, input int b);
    int hot = 0;
    case (c)
      1: begin
        if (m_act[b]) return 3;          // R7
        if (m_cnt[b] < T_RC) return 4;   // R8
        if (b != m_last && m_rrd < T_RRD) return 5;  // R9
      end
      4, 5: begin
        if (!m_act[b]) return 2;         // R6
        if (m_cnt[b] < T_RCD) return 1;  // R5
      end
      2: if (m_act[b] && m_cnt[b] < T_RAS_MIN) return 6;  // R10
      3: begin
        for (int i = 0; i < 4; i++) if (m_act[i] && m_cnt[i] < T_RAS_MIN) hot = 1;
        if (hot) return 6;               // R10
      end
      default: ;
    endcase
    return 0;
  endfunction

  function automatic string req_of(input int code);
    case (code)
      1: return "R5"; 2: return "R6"; 3: return "R7";
      4: return "R8"; 5: return "R9"; 6: return "R10";
      default: return "R13";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_act[i] = 0; m_row[i] = '0; m_cnt[i] = SATM; end
    m_rrd = SATM; m_last = 0; m_sticky = '0;
  endtask

  // called at a falling edge: drive, predict, wait one edge, compare
  task automatic step(input logic cs, ras, cas, we, input logic [1:0] ba, input logic [10:0] addr);
    int c, code, b;
    logic [3:0] exp_act, exp_od;
    cs_ni = cs; ras_ni = ras; cas_ni = cas; we_ni = we; ba_i = ba; addr_i = addr;
    c = dec(cs, ras, cas, we, addr[10]);
    b = int'(ba);
    code = rule(c, b);
    for (int i = 0; i < 4; i++) if (m_act[i] && m_cnt[i] > T_RAS_MAX) m_sticky[7] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (c == 1 && i == b) begin m_act[i] = 1; m_row[i] = addr; m_cnt[i] = 1; end
      else begin
        if (m_cnt[i] < SATM) m_cnt[i]++;
        if ((c == 2 && i == b) || c == 3) m_act[i] = 0;
      end
    end
    if (c == 1) begin m_rrd = 1; m_last = b; end
    else if (m_rrd < SATM) m_rrd++;
    if (code != 0) m_sticky[code] = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    for (int i = 0; i < 4; i++) begin
      exp_act[i] = m_act[i];
      exp_od[i]  = m_act[i] && m_cnt[i] > T_RAS_MAX;
    end
    chk(cmd_o == 3'(c), "R1", "cmd_o", cmd_o, c);
    chk(viol_code_o == 3'(code) && viol_o == (code != 0),
        req_of(code != 0 ? code : int'(viol_code_o)), "viol_code_o", viol_code_o, code);
    chk(bank_active_o == exp_act, c == 3 ? "R4" : (c == 2 ? "R3" : "R2"), "bank_active_o",
        bank_active_o, exp_act);
    for (int i = 0; i < 4; i++)
      if (m_act[i]) chk(open_row_o[i*11 +: 11] == m_row[i], "R2", "open_row_o", open_row_o[i*11 +: 11], m_row[i]);
    chk(overdue_o == exp_od, "R11", "overdue_o", overdue_o, exp_od);
    chk(viol_sticky_o == m_sticky, "R12", "viol_sticky_o", viol_sticky_o, m_sticky);
  endtask

  task automatic act(input int b, input int row);  step(0, 0, 1, 1, 2'(b), 11'(row)); endtask
  task automatic pre(input int b);                 step(0, 0, 1, 0, 2'(b), 11'h000); endtask
  task automatic prea(input int b);                step(0, 0, 1, 0, 2'(b), 11'h400); endtask
  task automatic rd(input int b);                  step(0, 1, 0, 1, 2'(b), 11'h012); endtask
  task automatic wr(input int b);                  step(0, 1, 0, 0, 2'(b), 11'h0a5); endtask
  task automatic nop(input int n);
    for (int i = 0; i < n; i++) step(0, 1, 1, 1, 2'(i), 11'h7ff);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    model_reset();
    repeat (3) @(negedge clk_i);
    // R13: reset state
    chk(cmd_o == 0 && viol_o == 0 && viol_code_o == 0, "R13", "cmd/viol after reset",
        {cmd_o, viol_o, viol_code_o}, 0);
    chk(bank_active_o == 0 && overdue_o == 0 && viol_sticky_o == 0, "R13", "state after reset",
        {bank_active_o, overdue_o, viol_sticky_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    act(0, 'h123);       // R13: expired timers, no violation
    act(1, 'h055);       // R9: gap 1 to other bank
    rd(0);               // R5: gap 2 < T_RCD
    nop(1);
    rd(0);               // gap 4, legal
    wr(2);               // R6: idle bank
    act(1, 'h3aa);       // R7: bank 1 already open
    pre(1);              // R10: early precharge
    act(1, 'h111);       // R8: same bank within T_RC
    pre(3);              // R3: idle bank, no violation
    nop(6);
    prea(2);             // R4: banks 0,1 closed, 2,3 idle
    act(2, 'h0f0);
    act(3, 'h0f1);       // R9
    step(1, 0, 0, 0, 2'd2, 11'h000);  // R1: deselected -> NOP
    step(0, 0, 0, 1, 2'd2, 11'h000);  // R1: other encoding
    step(0, 1, 0, 1, 2'd2, 11'h400);  // R1: read with bit 10 -> other
    nop(35);             // R11: overdue on banks 2,3, then sticky bit 7
    pre(2);
    prea(0);

    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [1:0]  b;
      logic [10:0] a;
      r = $urandom % 100;
      b = 2'($urandom);
      a = 11'($urandom);
      if (r < 38)      step(0, 1, 1, 1, b, a);
      else if (r < 42) step(1, 2'($urandom) == 0, 1'($urandom), 1'($urandom), b, a);
      else if (r < 60) step(0, 0, 1, 1, b, a);
      else if (r < 71) step(0, 0, 1, 0, b, {1'b0, a[9:0]});
      else if (r < 73) step(0, 0, 1, 0, b, {1'b1, a[9:0]});
      else if (r < 84) step(0, 1, 0, 1, b, {1'b0, a[9:0]});
      else if (r < 95) step(0, 1, 0, 0, b, {1'b0, a[9:0]});
      else             step(0, 1'($urandom), 0, 1'($urandom), b, {1'b1, a[9:0]});
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule